// File: doc/BRIEF.md
# Temperature Sensor Conversion Sequencer

This block is the digital control around an on-chip temperature sensor whose converter produces a 10-bit code. Software writes one configuration word. That word holds a clock divider, a sampling enable, a single-capture request and a free-running mode flag. The block divides the system clock down to a slow sensor tick. It times each conversion as a fixed number of those ticks. It then captures the converter's code into a status word together with a valid flag.

There are two ways to run it. In single-capture mode, software sets the request bit with sampling enabled. Exactly one conversion runs, and the request bit clears itself when the result lands. In free-running mode, conversions follow one another with no gap, and each new result overwrites the previous one. Clearing the enable stops everything at once. Translating the code into a temperature is left to software.

Top module: `sensor_seq_ctrl`

## Requirements
- R1: After reset the configuration readback and the status word are both all zeros, and no sensor tick is issued.
- R2: Configuration readback places the divider in bits 27:20, the enable in bit 8, the capture request in bit 7 and the free-running flag in bit 6. Every other bit reads 0, whatever was written to it.
- R3: While a conversion runs, `sns_tick` is high for one cycle in every D cycles, where D is the divider field. A divider of 0 behaves as 1, so the tick is then high every cycle.
- R4: With the free-running flag 0, a write that sets both enable and capture request starts exactly one conversion. The result appears in the status word D×CONV_TICKS+1 cycles after the write edge, and no later conversion follows.
- R5: The capture request bit reads back as 0 once its conversion has completed.
- R6: With enable and the free-running flag both 1, results land every D×CONV_TICKS cycles with no gap. The first result lands D×CONV_TICKS+1 cycles after the write edge.
- R7: Status bit 10 (valid) is 0 after reset and within one cycle after the enable is cleared. It sets with the first completed conversion and stays 1 while later results overwrite the data.
- R8: A capture request written while the enable is 0 starts nothing. It reads back as 0, and the status word is unchanged.
- R9: Clearing the enable in the middle of a conversion aborts it. No new result is captured, and the ticks stop.
- R10: Status bits 9:0 hold the converter code sampled on the completing cycle, intact over the full range 0 to 1023. They hold still between completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write word |
| cfg_rdata | output | 32 | Configuration readback |
| stat_rdata | output | 32 | Status word: valid at bit 10, code at bits 9:0 |
| sns_code | input | 10 | Code presented by the sensor converter |
| sns_tick | output | 1 | Slow sensor clock enable pulse |
| sns_busy | output | 1 | High while a conversion is in progress |

## Verification
The bench sweeps the divider through small values, the value 0 and the maximum. For each one it finds the exact cycle on which the result lands. An off-by-one divider, or a design that forgets to map 0 to 1, moves that cycle or changes the tick spacing. After each single capture the bench changes the converter code and waits several conversion periods. A request bit that does not self-clear shows up as a retriggered conversion. In free-running mode each result must match the code presented during its own conversion. The bench also clears the enable mid-conversion. A design that lets that conversion finish, or leaves the valid flag set, is caught there.

// File: rtl/sseq_pkg.sv
package sseq_pkg;
  localparam int DIV_W          = 8;
  localparam int CODE_W         = 10;
  localparam int CFG_DIV_LSB    = 20;
  localparam int CFG_EN_BIT     = 8;
  localparam int CFG_REQ_BIT    = 7;
  localparam int CFG_FREE_BIT   = 6;
  localparam int STAT_VALID_BIT = 10;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             en;
    logic             req;
    logic             free;
  } sseq_cfg_t;

  // divider value actually used: zero behaves as one
  function automatic logic [DIV_W-1:0] eff_div(input logic [DIV_W-1:0] raw);
    return (raw == '0) ? DIV_W'(1) : raw;
  endfunction

  // system cycles taken by one conversion
  function automatic int conv_cycles(input int raw_div, input int ticks);
    return ((raw_div == 0) ? 1 : raw_div) * ticks;
  endfunction
endpackage

// File: rtl/sseq_cfg_reg.sv
module sseq_cfg_reg
  import sseq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [31:0] wdata,
  input  logic        conv_done,
  output sseq_cfg_t   cfg
);
  logic unused_bits;
  assign unused_bits = ^{wdata[31:28], wdata[19:9], wdata[5:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (we) begin
      cfg.div  <= wdata[CFG_DIV_LSB +: DIV_W];
      cfg.en   <= wdata[CFG_EN_BIT];
      cfg.free <= wdata[CFG_FREE_BIT];
      cfg.req  <= wdata[CFG_REQ_BIT] & wdata[CFG_EN_BIT];
    end else if (conv_done) begin
      cfg.req  <= 1'b0;
    end
  end
endmodule

// File: rtl/sseq_clkdiv.sv
module sseq_clkdiv
  import sseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_raw,
  output logic             tick,
  output logic [DIV_W-1:0] cnt,
  output logic [DIV_W-1:0] div_used
);
  assign div_used = eff_div(div_raw);
  assign tick     = run && (cnt >= div_used - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!run || tick)   cnt <= '0;
    else                     cnt <= cnt + DIV_W'(1);
  end
endmodule

// File: rtl/sseq_conv_fsm.sv
module sseq_conv_fsm #(
  parameter int CONV_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic free,
  input  logic req,
  input  logic tick,
  output logic busy,
  output logic done
);
  localparam int TW = (CONV_TICKS > 1) ? $clog2(CONV_TICKS) : 1;

  logic [TW-1:0] tcnt;
  logic          launch;

  assign launch = !busy && en && (free || req);
  assign done   = busy && en && tick && (tcnt == TW'(CONV_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      tcnt <= '0;
    end else if (!en) begin
      busy <= 1'b0;
      tcnt <= '0;
    end else if (launch) begin
      busy <= 1'b1;
      tcnt <= '0;
    end else if (done) begin
      busy <= free;
      tcnt <= '0;
    end else if (tick) begin
      tcnt <= tcnt + TW'(1);
    end
  end
endmodule

// File: rtl/sseq_result.sv
module sseq_result
  import sseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              done,
  input  logic [CODE_W-1:0] code,
  output logic [CODE_W-1:0] data,
  output logic              valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data  <= '0;
      valid <= 1'b0;
    end else begin
      if (done) data <= code;
      if (!en)        valid <= 1'b0;
      else if (done)  valid <= 1'b1;
    end
  end
endmodule

// File: rtl/sensor_seq_ctrl.sv
module sensor_seq_ctrl
  import sseq_pkg::*;
#(
  parameter int CONV_TICKS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic [31:0]       stat_rdata,
  input  logic [CODE_W-1:0] sns_code,
  output logic              sns_tick,
  output logic              sns_busy
);
  sseq_cfg_t        cfg_q;
  logic             cfg_en, cfg_free;
  logic             conv_busy, conv_tick, conv_done;
  logic             res_valid;
  logic [CODE_W-1:0] res_data;
  logic [DIV_W-1:0] div_cnt, div_used;

  assign cfg_en   = cfg_q.en;
  assign cfg_free = cfg_q.free;

  sseq_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .conv_done(conv_done), .cfg(cfg_q)
  );

  sseq_clkdiv u_div (
    .clk(clk), .rst_n(rst_n), .run(conv_busy && cfg_en), .div_raw(cfg_q.div),
    .tick(conv_tick), .cnt(div_cnt), .div_used(div_used)
  );

  sseq_conv_fsm #(.CONV_TICKS(CONV_TICKS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .en(cfg_en), .free(cfg_free), .req(cfg_q.req),
    .tick(conv_tick), .busy(conv_busy), .done(conv_done)
  );

  sseq_result u_res (
    .clk(clk), .rst_n(rst_n), .en(cfg_en), .done(conv_done), .code(sns_code),
    .data(res_data), .valid(res_valid)
  );

  always_comb begin
    cfg_rdata = '0;
    cfg_rdata[CFG_DIV_LSB +: DIV_W] = cfg_q.div;
    cfg_rdata[CFG_EN_BIT]           = cfg_q.en;
    cfg_rdata[CFG_REQ_BIT]          = cfg_q.req;
    cfg_rdata[CFG_FREE_BIT]         = cfg_q.free;
    stat_rdata = '0;
    stat_rdata[CODE_W-1:0]          = res_data;
    stat_rdata[STAT_VALID_BIT]      = res_valid;
  end

  assign sns_tick = conv_tick;
  assign sns_busy = conv_busy;
endmodule

// File: rtl/sseq_chk.sv
module sseq_chk
  import sseq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              free,
  input logic              busy,
  input logic              tick,
  input logic              done,
  input logic              valid,
  input logic [CODE_W-1:0] data,
  input logic [DIV_W-1:0]  cnt
);
  // R7
  valid_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) !en |=> !valid);
  // R7
  valid_set_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> valid);
  // R3
  div_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n) tick |=> (cnt == '0));
  // R4
  single_end_chk: assert property (@(posedge clk) disable iff (!rst_n) (done && !free) |=> !busy);
  // R6
  free_keep_chk: assert property (@(posedge clk) disable iff (!rst_n) (done && free) |=> busy);
  // R9
  tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) !en |-> !tick);
  // R10
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !done |=> $stable(data));
endmodule

bind sensor_seq_ctrl sseq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(cfg_en), .free(cfg_free), .busy(conv_busy),
  .tick(conv_tick), .done(conv_done), .valid(res_valid), .data(res_data),
  .cnt(div_cnt)
);

// File: tb/tb_sensor_seq_ctrl.sv
`timescale 1ns/1ps
module tb_sensor_seq_ctrl;
  localparam int CT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata, stat_rdata;
  logic [9:0]  sns_code = '0;
  logic        sns_tick, sns_busy;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  sensor_seq_ctrl #(.CONV_TICKS(CT)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .stat_rdata(stat_rdata), .sns_code(sns_code),
    .sns_tick(sns_tick), .sns_busy(sns_busy)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    wait (cyc > 100000);
    checks++; errors++;
    $display("FAIL watchdog: run did not complete");
    report();
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cfg_word(input int d, input bit en, input bit rq, input bit fr);
    return {4'h0, 8'(d), 11'h0, en, rq, fr, 6'h0};
  endfunction

  task automatic wr(input logic [31:0] w);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int ticks, first, bad, n, eff;
    logic [9:0] code, codes[4];
    int divs[9] = '{0, 1, 2, 3, 4, 5, 6, 7, 255};

    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    check("R1 cfg", cfg_rdata, 32'h0);
    check("R1 stat", stat_rdata, 32'h0);
    check("R1 tick", {31'h0, sns_tick}, 32'h0);

    // R2 field positions, unused bits read 0
    wr(32'hF000_3E3F | cfg_word(8'hA5, 0, 0, 1));
    check("R2 readback", cfg_rdata, (32'hA5 << 20) | (32'h1 << 6));
    wr(32'h0);

    // R8 request while disabled
    wr(cfg_word(2, 0, 1, 0));
    ticks = 0;
    for (int k = 0; k < 20; k++) begin step(1); ticks += sns_tick; end
    check("R8 no ticks", ticks, 0);
    check("R8 req reads 0", {31'h0, cfg_rdata[7]}, 32'h0);
    check("R8 stat unchanged", stat_rdata, 32'h0);

    // single-capture sweep over divider values
    foreach (divs[i]) begin
      wr(32'h0);
      step(2);
      check("R7 valid after disable", {31'h0, stat_rdata[10]}, 32'h0);
      eff  = (divs[i] == 0) ? 1 : divs[i];
      n    = eff * CT;
      code = (i == 1) ? 10'd1023 : 10'((divs[i] * 181 + 37) % 1024);
      sns_code = code;
      wr(cfg_word(divs[i], 1, 1, 0));
      ticks = 0; first = 0;
      for (int k = 1; k <= n + 1; k++) begin
        step(1);
        if (k <= n && sns_tick) begin
          ticks++;
          if (first == 0) first = k;
        end
        if (k == n) check("R4 not yet valid", {31'h0, stat_rdata[10]}, 32'h0);
      end
      check("R4 valid at D*T+1", {31'h0, stat_rdata[10]}, 32'h1);
      check("R10 code captured", {22'h0, stat_rdata[9:0]}, {22'h0, code});
      check("R3 tick count", ticks, CT);
      check("R3 first tick spacing", first, eff);
      check("R5 req self-clear", cfg_rdata, cfg_word(divs[i], 1, 0, 0));
      sns_code = code ^ 10'h155;
      step(3 * n + 5);
      check("R4 single conversion", {21'h0, stat_rdata[10:0]}, {21'h0, 1'b1, code});
      check("R4 idle", {31'h0, sns_busy}, 32'h0);
    end

    // R6 free-running, divider 3
    wr(32'h0);
    step(2);
    for (int j = 0; j < 4; j++) codes[j] = 10'(j * 300 + 11);
    sns_code = codes[0];
    wr(cfg_word(3, 1, 0, 1));
    bad = 0;
    for (int k = 1; k <= 3 * 12 + 1; k++) begin
      step(1);
      if (sns_tick !== (k % 3 == 0)) bad++;
      if (k > 1 && (k - 1) % 12 == 0) begin
        check("R6 result in order", {22'h0, stat_rdata[9:0]}, {22'h0, codes[(k - 1) / 12 - 1]});
        check("R7 valid stays set", {31'h0, stat_rdata[10]}, 32'h1);
        sns_code = codes[(k - 1) / 12];
      end
    end
    check("R3 tick cadence free-running", bad, 0);

    // R9 abort mid-conversion
    step(4);
    code = stat_rdata[9:0];
    sns_code = 10'h2AA;
    wr(32'h0);
    ticks = 0;
    for (int k = 0; k < 30; k++) begin step(1); ticks += sns_tick; end
    check("R9 data kept", {22'h0, stat_rdata[9:0]}, {22'h0, code});
    check("R9 valid cleared", {31'h0, stat_rdata[10]}, 32'h0);
    check("R9 no ticks", ticks, 0);
    check("R9 idle", {31'h0, sns_busy}, 32'h0);

    // R3 divider 0 acts as 1 while free-running
    sns_code = 10'h000;
    wr(cfg_word(0, 1, 0, 1));
    ticks = 0;
    for (int k = 0; k < 8; k++) begin step(1); ticks += sns_tick; end
    check("R3 zero divider every cycle", ticks, 8);
    step(1);
    check("R10 code zero", {21'h0, stat_rdata[10:0]}, {21'h0, 1'b1, 10'h000});

    report();
  end
endmodule